// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit works out the vector length granted when a vector configuration instruction runs. A request carries an application vector length (AVL), which comes either from a full-width register operand or from a short zero-extended immediate. It also carries the element width code, the length multiplier code, the two agnostic-policy bits and a split-policy select. From a fixed register width the unit derives the largest number of elements a register group can hold (VLMAX). It returns the granted length, the new packed type value and an illegal-type flag. All three are registered, and they appear one cycle after the request strobe.

Some instructions work on groups of elements, and their stripmining loops must never cut a group in two. When the request is larger than VLMAX, the grant is therefore always VLMAX or a positive multiple of the largest supported group size. With the split policy selected, a request between VLMAX and twice VLMAX is divided into two near-equal passes, and the first pass is rounded up to whole groups. A type value the unit cannot support produces a zero length and a cleared type, with the illegal flag set.

Top module: `vlx_setter`

## Requirements
- R1: While reset is held low at a clock edge, rsp_valid becomes 0, rsp_vl becomes 0, rsp_vtype becomes 0 and rsp_vill becomes 1.
- R2: rsp_valid is 1 in exactly the cycle after each cycle in which req_valid is 1. When req_valid is 0, rsp_vl, rsp_vtype and rsp_vill keep their values.
- R3: When req_use_imm is 1 the AVL is req_avl_imm, zero-extended, and req_avl_reg is ignored. When req_use_imm is 0 the AVL is req_avl_reg and req_avl_imm is ignored.
- R4: Element width codes 0,1,2,3 select 8,16,32,64 bits. Multiplier codes 0,1,2,3 select 1,2,4,8, and codes 5,6,7 select 1/8,1/4,1/2. VLMAX = VLEN × LMUL / SEW.
- R5: The type is illegal when the width code is 4 to 7, when SEW > ELEN, when the multiplier code is 4, or when SEW > LMUL × ELEN. An illegal type gives rsp_vill=1, rsp_vl=0 and rsp_vtype=0.
- R6: For a legal type with AVL ≤ VLMAX, rsp_vl equals AVL, and this includes AVL = 0.
- R7: For a legal type with AVL > VLMAX and req_split=0, rsp_vl equals VLMAX.
- R8: For a legal type with req_split=1 and VLMAX < AVL < 2×VLMAX, rsp_vl = min(VLMAX, ceil(AVL/2) rounded up to a multiple of EGS_MAX).
- R9: For a legal type with req_split=1 and AVL ≥ 2×VLMAX, rsp_vl equals VLMAX.
- R10: Whenever AVL > VLMAX for a legal type, rsp_vl is either VLMAX or a non-zero multiple of EGS_MAX.
- R11: For a legal type, rsp_vill=0 and rsp_vtype holds {mask_agn, tail_agn, sew[2:0], lmul[2:0]} in bits 7, 6, 5:3 and 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_use_imm | input | 1 | Take AVL from the immediate instead of the register |
| req_avl_reg | input | XLEN | AVL from the register operand |
| req_avl_imm | input | IMM_W | AVL from the immediate field |
| req_sew | input | 3 | Element width code |
| req_lmul | input | 3 | Length multiplier code |
| req_tail_agn | input | 1 | Tail-agnostic policy bit |
| req_mask_agn | input | 1 | Mask-agnostic policy bit |
| req_split | input | 1 | Select the two-pass split policy for long requests |
| rsp_valid | output | 1 | Result valid |
| rsp_vl | output | VL_W | Granted vector length |
| rsp_vtype | output | 8 | Packed type value written back |
| rsp_vill | output | 1 | Illegal-type flag |

## Verification
Every result of this unit (the valid pulse, the granted length, the type value and the illegal flag) is due exactly one clock edge after the request strobe. Between requests each result must hold its value. The bench keeps a behavioural model that is updated on the same rising edge as the design. It then compares all four outputs with the model on the following falling edge, every cycle. Back-to-back requests and idle gaps therefore test both the one-cycle latency and the hold behaviour, and the over-long AVL cases are also checked directly against the whole-group rule.

// File: rtl/vlx_pkg.sv
// Shared types and encodings for the vector length setting unit.
// Assumes the standard 3-bit width and multiplier codes described in the brief.
package vlx_pkg;

    // Multiplier code that no legal type may use
    localparam logic [2:0] LMUL_RSVD = 3'b100;

    // Packed type value returned to the configuration register
    typedef struct packed {
        logic       mask_agn;
        logic       tail_agn;
        logic [2:0] sew;
        logic [2:0] lmul;
    } vtype_t;

endpackage

// File: rtl/vlx_type_check.sv
// Type legality and VLMAX computation.
// Works entirely on base-2 logarithms: VLMAX is always a power of two, so a
// single shift replaces the multiply and divide. Assumes VLEN >= ELEN, both
// powers of two, so any legal type yields VLMAX >= 1.
module vlx_type_check
    import vlx_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int ELEN = 64,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input  logic [2:0]      sew_code,
    input  logic [2:0]      lmul_code,
    output logic            type_ok,
    output logic [VL_W-1:0] vlmax
);

    localparam int VLEN_LG = $clog2(VLEN);
    localparam int ELEN_LG = $clog2(ELEN);

    int   sew_lg;
    int   mul_lg;
    int   div_lg;
    int   exp_lg;
    logic sew_ok;
    logic lmul_ok;
    logic frac_ok;

    // Decode the codes into log2 terms and judge legality
    always_comb begin
        sew_lg  = 3 + int'(sew_code[1:0]);
        mul_lg  = 0;
        div_lg  = 0;
        lmul_ok = 1'b1;
        if (lmul_code == LMUL_RSVD) begin
            lmul_ok = 1'b0;
        end else if (lmul_code[2]) begin
            div_lg = 8 - int'(lmul_code);
        end else begin
            mul_lg = int'(lmul_code[1:0]);
        end
        sew_ok  = (sew_code[2] == 1'b0) && (sew_lg <= ELEN_LG);
        frac_ok = (sew_lg + div_lg) <= ELEN_LG;
        type_ok = sew_ok && lmul_ok && frac_ok;
    end

    // Form VLMAX as a single power of two
    always_comb begin
        exp_lg = VLEN_LG + mul_lg - div_lg - sew_lg;
        vlmax  = '0;
        if (type_ok && (exp_lg >= 0) && (exp_lg < VL_W)) begin
            vlmax = VL_W'(1) << exp_lg;
        end
    end

endmodule

// File: rtl/vlx_avl_select.sv
// AVL source select: the zero-extended immediate or the register operand.
// Assumes IMM_W < XLEN.
module vlx_avl_select #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 5
) (
    input  logic             use_imm,
    input  logic [XLEN-1:0]  avl_reg,
    input  logic [IMM_W-1:0] avl_imm,
    output logic [XLEN-1:0]  avl
);

    // Pick the active source and widen the immediate with zeros
    always_comb begin
        if (use_imm) begin
            avl = {{(XLEN-IMM_W){1'b0}}, avl_imm};
        end else begin
            avl = avl_reg;
        end
    end

endmodule

// File: rtl/vlx_grant.sv
// Granted-length policy. A request that fits is granted as it is. A long
// request gets VLMAX, unless the split policy is selected and the request is
// below twice VLMAX: it is then halved (rounded up), brought up to whole
// groups and capped at VLMAX. Assumes EGS_MAX is a power of two and that
// 2*VLEN fits in XLEN.
module vlx_grant #(
    parameter int XLEN    = 32,
    parameter int VL_W    = 8,
    parameter int EGS_MAX = 4
) (
    input  logic [XLEN-1:0] avl,
    input  logic [VL_W-1:0] vlmax,
    input  logic            type_ok,
    input  logic            split,
    output logic [VL_W-1:0] vl
);

    logic [XLEN-1:0] vmx;
    logic [XLEN-1:0] half;
    logic [XLEN-1:0] grp;

    // Widen VLMAX and form ceil(avl/2) without overflow
    always_comb begin
        vmx  = XLEN'(vlmax);
        half = (avl >> 1) + XLEN'(avl[0]);
    end

    // Round the half length up to whole groups when groups are larger than one
    generate
        if (EGS_MAX > 1) begin : g_round
            localparam logic [XLEN-1:0] GMASK = XLEN'(EGS_MAX - 1);
            always_comb grp = (half + GMASK) & ~GMASK;
        end else begin : g_pass
            always_comb grp = half;
        end
    endgenerate

    // Choose the grant
    always_comb begin
        if (!type_ok) begin
            vl = '0;
        end else if (avl <= vmx) begin
            vl = avl[VL_W-1:0];
        end else if (split && (avl < (vmx << 1))) begin
            vl = (grp < vmx) ? grp[VL_W-1:0] : vlmax;
        end else begin
            vl = vlmax;
        end
    end

endmodule

// File: rtl/vlx_setter.sv
// Vector length setting unit, top level.
// Takes one configuration request per req_valid pulse and registers the
// granted length, the type value and the illegal flag one cycle later. The
// outputs hold between requests. Synchronous active-low reset.
module vlx_setter
    import vlx_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 5,
    parameter int VLEN    = 128,
    parameter int ELEN    = 64,
    parameter int EGS_MAX = 4,
    localparam int VL_W   = $clog2(VLEN) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_use_imm,
    input  logic [XLEN-1:0]  req_avl_reg,
    input  logic [IMM_W-1:0] req_avl_imm,
    input  logic [2:0]       req_sew,
    input  logic [2:0]       req_lmul,
    input  logic             req_tail_agn,
    input  logic             req_mask_agn,
    input  logic             req_split,
    output logic             rsp_valid,
    output logic [VL_W-1:0]  rsp_vl,
    output logic [7:0]       rsp_vtype,
    output logic             rsp_vill
);

    logic [XLEN-1:0] avl_sel;
    logic            type_ok;
    logic [VL_W-1:0] vlmax_w;
    logic [VL_W-1:0] vl_next;
    vtype_t          vtype_next;

    logic            valid_q;
    logic [VL_W-1:0] vl_q;
    vtype_t          vtype_q;
    logic            vill_q;

    vlx_avl_select #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_avl (
        .use_imm (req_use_imm),
        .avl_reg (req_avl_reg),
        .avl_imm (req_avl_imm),
        .avl     (avl_sel)
    );

    vlx_type_check #(
        .VLEN (VLEN),
        .ELEN (ELEN)
    ) u_type (
        .sew_code  (req_sew),
        .lmul_code (req_lmul),
        .type_ok   (type_ok),
        .vlmax     (vlmax_w)
    );

    vlx_grant #(
        .XLEN    (XLEN),
        .VL_W    (VL_W),
        .EGS_MAX (EGS_MAX)
    ) u_grant (
        .avl     (avl_sel),
        .vlmax   (vlmax_w),
        .type_ok (type_ok),
        .split   (req_split),
        .vl      (vl_next)
    );

    // Pack the type value, clearing every field when the type is illegal
    always_comb begin
        if (type_ok) begin
            vtype_next = '{mask_agn: req_mask_agn, tail_agn: req_tail_agn,
                           sew: req_sew, lmul: req_lmul};
        end else begin
            vtype_next = '0;
        end
    end

    // Result registers: load on a request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vl_q    <= '0;
            vtype_q <= '0;
            vill_q  <= 1'b1;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                vl_q    <= vl_next;
                vtype_q <= vtype_next;
                vill_q  <= ~type_ok;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_vl    = vl_q;
    assign rsp_vtype = vtype_q;
    assign rsp_vill  = vill_q;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_vl) && $stable(rsp_vtype) && $stable(rsp_vill))); // R2
    AST_VILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vill |-> (rsp_vl == '0 && rsp_vtype == '0)); // R5
    AST_VLMAX_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && type_ok) |-> ($countones(vlmax_w) == 1)); // R4
    AST_VL_NOT_ABOVE_AVL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (XLEN'(vl_next) <= avl_sel)); // R6
    AST_VL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && type_ok) |-> (vl_next <= vlmax_w)); // R7
    AST_GROUP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && type_ok && (avl_sel > XLEN'(vlmax_w))) |->
        ((vl_next == vlmax_w) ||
         ((vl_next != '0) && ((vl_next & VL_W'(EGS_MAX - 1)) == '0)))); // R10

endmodule

// File: tb/vlx_setter_test.sv
// Self-checking bench for vlx_setter with a behavioural reference model.
module vlx_setter_test;

    localparam int VLEN  = 128;
    localparam int ELEN  = 64;
    localparam int EGS   = 4;
    localparam int XLEN  = 32;
    localparam int IMM_W = 5;
    localparam int VL_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_use_imm = 1'b0;
    logic [XLEN-1:0]  req_avl_reg = '0;
    logic [IMM_W-1:0] req_avl_imm = '0;
    logic [2:0]       req_sew = '0;
    logic [2:0]       req_lmul = '0;
    logic             req_tail_agn = 1'b0;
    logic             req_mask_agn = 1'b0;
    logic             req_split = 1'b0;
    logic             rsp_valid;
    logic [VL_W-1:0]  rsp_vl;
    logic [7:0]       rsp_vtype;
    logic             rsp_vill;

    always #5 clk = ~clk;

    vlx_setter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_use_imm  (req_use_imm),
        .req_avl_reg  (req_avl_reg),
        .req_avl_imm  (req_avl_imm),
        .req_sew      (req_sew),
        .req_lmul     (req_lmul),
        .req_tail_agn (req_tail_agn),
        .req_mask_agn (req_mask_agn),
        .req_split    (req_split),
        .rsp_valid    (rsp_valid),
        .rsp_vl       (rsp_vl),
        .rsp_vtype    (rsp_vtype),
        .rsp_vill     (rsp_vill)
    );

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    armed = 1'b0;
    bit    m_valid;
    int    m_vl;
    int    m_vtype;
    bit    m_vill;
    bit    m_over;
    int    m_vlmax;
    string m_tag;

    // Reference computation from the requirements alone
    function automatic void ref_calc(input bit use_imm, input logic [31:0] areg,
                                     input logic [4:0] aimm, input logic [2:0] sew,
                                     input logic [2:0] lmul, input bit ta, input bit ma,
                                     input bit split, output int vl, output int vt,
                                     output bit ill, output string tag, output bit over,
                                     output int vmax);
        longint avl;
        int     sew_bits = 8;
        int     num = 1;
        int     den = 1;
        bit     ok = 1'b1;
        longint h;
        longint g;
        avl  = use_imm ? longint'(aimm) : longint'(areg);
        over = 1'b0;
        vmax = 0;
        if (sew > 3) ok = 1'b0;
        else begin
            sew_bits = 8 << sew;
            if (sew_bits > ELEN) ok = 1'b0;
        end
        case (lmul)
            3'd0, 3'd1, 3'd2, 3'd3: num = 1 << lmul;
            3'd4: ok = 1'b0;
            3'd5: den = 8;
            3'd6: den = 4;
            default: den = 2;
        endcase
        if (ok && (sew_bits * den > ELEN)) ok = 1'b0;
        if (!ok) begin
            vl = 0; vt = 0; ill = 1'b1; tag = "R5";
            return;
        end
        ill  = 1'b0;
        vmax = VLEN * num / (sew_bits * den);
        vt   = int'(ma) * 128 + int'(ta) * 64 + int'(sew) * 8 + int'(lmul);
        if (avl <= vmax) begin
            vl = int'(avl); tag = "R6 R4";
        end else begin
            over = 1'b1;
            if (!split) begin
                vl = vmax; tag = "R7 R4";
            end else if (avl < 2 * vmax) begin
                h  = (avl + 1) / 2;
                g  = ((h + EGS - 1) / EGS) * EGS;
                vl = (g < vmax) ? int'(g) : vmax;
                tag = "R8 R4";
            end else begin
                vl = vmax; tag = "R9 R4";
            end
        end
        if (use_imm) tag = {tag, " R3"};
    endfunction

    // Model state advances on the same edge as the design
    always @(posedge clk) begin
        int    vl;
        int    vt;
        int    vmax;
        bit    ill;
        bit    over;
        string tag;
        armed <= 1'b1;
        if (!rst_n) begin
            m_valid <= 1'b0; m_vl <= 0; m_vtype <= 0; m_vill <= 1'b1;
            m_over <= 1'b0; m_vlmax <= 0; m_tag <= "R1";
        end else begin
            m_valid <= req_valid;
            if (req_valid) begin
                ref_calc(req_use_imm, req_avl_reg, req_avl_imm, req_sew, req_lmul,
                         req_tail_agn, req_mask_agn, req_split, vl, vt, ill, tag,
                         over, vmax);
                m_vl <= vl; m_vtype <= vt; m_vill <= ill; m_tag <= tag;
                m_over <= over; m_vlmax <= vmax;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", rq, act, exp);
        end
    endtask

    // Compare every output with the model away from the rising edge
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(rst_n ? "R2 valid" : "R1 valid", 32'(rsp_valid), 32'(m_valid));
            chk({m_tag, " vl"}, 32'(rsp_vl), 32'(m_vl));
            chk(m_vill ? "R5 vtype" : "R11 vtype", 32'(rsp_vtype), 32'(m_vtype));
            chk(m_vill ? "R5 vill" : "R11 vill", 32'(rsp_vill), 32'(m_vill));
            if (rst_n && m_valid && m_over && !m_vill) begin
                chk("R10 whole groups",
                    32'((int'(rsp_vl) == m_vlmax) ||
                        (rsp_vl != 0 && (int'(rsp_vl) % EGS) == 0)), 32'd1);
            end
        end
    end

    task automatic issue(input bit use_imm, input logic [31:0] areg, input logic [4:0] aimm,
                         input logic [2:0] sew, input logic [2:0] lmul, input bit split,
                         input bit ta, input bit ma, input int gap);
        @(negedge clk);
        #1;
        req_valid = 1'b1; req_use_imm = use_imm; req_avl_reg = areg; req_avl_imm = aimm;
        req_sew = sew; req_lmul = lmul; req_split = split;
        req_tail_agn = ta; req_mask_agn = ma;
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        req_avl_reg = 32'hDEAD_BEEF; req_avl_imm = 5'h1F; req_sew = 3'd7; req_lmul = 3'd4;
        repeat (gap) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int avls[9] = '{0, 5, 9, 17, 33, 65, 129, 200, 300};
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R6: fits, SEW=8 LMUL=1 gives VLMAX 16
        issue(0, 32'd0, 5'd0, 3'd0, 3'd0, 0, 0, 0, 1);
        issue(0, 32'd16, 5'd3, 3'd0, 3'd0, 1, 1, 0, 0);
        // R7: over, no split
        issue(0, 32'd17, 5'd0, 3'd0, 3'd0, 0, 0, 1, 0);
        // R8: 17->12, 20->12, 31->16
        issue(0, 32'd17, 5'd0, 3'd0, 3'd0, 1, 0, 0, 0);
        issue(0, 32'd20, 5'd0, 3'd0, 3'd0, 1, 1, 1, 2);
        issue(0, 32'd31, 5'd0, 3'd0, 3'd0, 1, 0, 0, 0);
        // R9: at and far beyond twice VLMAX
        issue(0, 32'd32, 5'd0, 3'd0, 3'd0, 1, 0, 0, 0);
        issue(0, 32'hFFFF_FFFF, 5'd0, 3'd0, 3'd0, 1, 0, 0, 1);
        // R3: immediate source, register ignored
        issue(1, 32'd1000, 5'd9, 3'd0, 3'd0, 0, 0, 0, 0);
        issue(1, 32'd2, 5'd31, 3'd0, 3'd0, 1, 0, 0, 0);
        // R5: illegal types
        issue(0, 32'd4, 5'd0, 3'd3, 3'd5, 0, 1, 1, 0);
        issue(0, 32'd4, 5'd0, 3'd4, 3'd0, 0, 1, 1, 0);
        issue(0, 32'd4, 5'd0, 3'd0, 3'd4, 0, 1, 1, 0);
        issue(0, 32'd4, 5'd0, 3'd2, 3'd6, 0, 0, 0, 0);
        // R8 cap: SEW=16 LMUL=1/4 gives VLMAX 2, AVL 3 -> 2
        issue(0, 32'd3, 5'd0, 3'd1, 3'd6, 1, 0, 0, 0);
        // Sweep every code pair
        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < 8; l++) begin
                for (int a = 0; a < 9; a++) begin
                    for (int sp = 0; sp < 2; sp++) begin
                        issue(a % 3 == 0, 32'(avls[a]), 5'(avls[a]), 3'(s), 3'(l),
                              sp[0], a[0], sp[0] ^ a[1], (a + sp) % 2);
                    end
                end
            end
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule